// File: doc/BRIEF.md
# Extended-Format Target Address Unit

This block is the decode and effective-address stage of an accumulator machine with a 20-bit address space. It accepts one fetched instruction together with the already advanced program counter, the base register and the index register. From six mode flags it works out the instruction length, computes the target address, and classifies how the operand is to be used: as an immediate value, through a pointer held in memory, or as a plain memory address. Combinations of flags that make no sense are reported as illegal.

When the operand is reached through a pointer, the block asks the memory system for the pointer word over a request/acknowledge handshake and returns the pointer as the final address. It reads no operand data itself. Instead it tells the next stage whether an operand read is needed. A legacy mode, selected when both operand-use flags are clear, turns three flag bits into upper address bits so that older code keeps working.

The instruction word is 32 bits. Bit 31 is the first byte fetched. A 3-byte instruction occupies bits 31..8, and its bits 7..0 are ignored. Flag positions: n = bit 25, i = bit 24, x = bit 23, b = bit 22, p = bit 21, e = bit 20. Bits 31..26 hold the opcode, which this block does not use.

Top module: `xta_unit`

## Requirements
- R1: out_len is 4 when e=1 and at least one of n and i is set. Otherwise out_len is 3. This includes the legacy mode, where e is an address bit.
- R2: With b=p=0 in a non-legacy instruction, the address field is used unchanged. For e=0 this is the 12-bit field in bits 19..8, zero-extended. For e=1 it is the 20-bit field in bits 19..0.
- R3: With p=1, b=0, e=0 the target is PC plus the 12-bit field read as a signed two's complement number, taken modulo 2^20.
- R4: With b=1, p=0, e=0 the target is the base register plus the 12-bit field read as an unsigned number, taken modulo 2^20.
- R5: With x=1 in a legal instruction, the index register is added into the target address, modulo 2^20.
- R6: n=0, i=1 is immediate. out_use is 1, out_read is 0, and no memory request is made.
- R7: n=1, i=0 is indirect. mem_req rises with mem_addr equal to the computed target and holds both until mem_ack. out_ta then equals mem_rdata[19:0], out_use is 2 and out_read is 1.
- R8: n=1, i=1 is simple addressing. out_use is 0 and out_read is 1.
- R9: n=0, i=0 is legacy mode. The target is bits 22..8 as a 15-bit unsigned address, plus the index register when x=1. In this mode out_use is 0, out_read is 1, out_len is 3, and the instruction is never illegal.
- R10: A non-legacy instruction is illegal when any of these holds: x=1 together with immediate or indirect; b=p=1; or e=1 with b or p set. An illegal instruction gives out_illegal=1, out_ta=0 and out_read=0, and makes no memory request.
- R11: in_ready is high only when the block is idle. out_valid is a one-cycle pulse. For non-indirect instructions it comes in the cycle after acceptance. For indirect instructions it comes in the cycle after the edge at which mem_req and mem_ack are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented |
| in_ready | output | 1 | Block idle, instruction accepted on valid |
| in_word | input | 32 | Fetched instruction, first byte in bits 31..24 |
| in_pc | input | 20 | Advanced program counter |
| in_base | input | 20 | Base register value |
| in_index | input | 20 | Index register value |
| mem_req | output | 1 | Pointer word read request |
| mem_addr | output | 20 | Address of the pointer word |
| mem_ack | input | 1 | Pointer word returned |
| mem_rdata | input | 24 | Pointer word, low 20 bits used |
| out_valid | output | 1 | Result pulse |
| out_ta | output | 20 | Final target address |
| out_use | output | 2 | 0 simple, 1 immediate, 2 indirect |
| out_len | output | 3 | Instruction length in bytes |
| out_read | output | 1 | Operand read needed by the next stage |
| out_illegal | output | 1 | Illegal flag combination |

## Verification
The bench goes after the address sums that wrap past 2^20. A PC-relative field with its top bit set must subtract, not add, and a design that zero-extends it would land 4096 bytes too far. A base near the top of memory plus a displacement must wrap to low addresses rather than be clipped. Legacy words with b, p or e set must use those bits as address bits; a design that decoded them as modes would take a relative path or report a 4-byte length. Indexed immediate, indexed indirect and both-relative words must come back flagged with no memory request. Indirect fetches with stalled acknowledges must keep the request address steady and return the pointer, not the first-level address.

// File: rtl/xta_pkg.sv
package xta_pkg;

   typedef enum logic [1:0] {
      USE_SIMPLE = 2'd0,
      USE_IMM    = 2'd1,
      USE_IND    = 2'd2
   } use_e;

   typedef enum logic [1:0] {
      SRC_ZERO = 2'd0,
      SRC_PC   = 2'd1,
      SRC_BASE = 2'd2
   } src_e;

   typedef struct packed {
      logic n;
      logic i;
      logic x;
      logic b;
      logic p;
      logic e;
   } flags_t;

endpackage

// File: rtl/xta_decode.sv
module xta_decode
   import xta_pkg::*;
#(
   parameter int IW           = 32,
   parameter int OPW          = 6,
   parameter int DISPW        = 12,
   parameter int AW           = 20,
   parameter bit REL4_ILLEGAL = 1'b1
) (
   input  logic [IW-1:0] word,
   output flags_t        fl,
   output use_e          use_o,
   output logic          ill_o,
   output logic [2:0]    len_o,
   output src_e          src_o,
   output logic [AW-1:0] off_o,
   output logic          idx_en_o
);
   localparam int FLW  = 6;
   localparam int EXTW = IW - OPW - FLW;
   localparam int LEGW = DISPW + 3;
   localparam int DTOP = EXTW - 1;
   localparam int LTOP = EXTW + 2;

   logic [DISPW-1:0] disp_f;
   logic [EXTW-1:0]  ext_f;
   logic [LEGW-1:0]  leg_f;
   logic             legacy;
   logic             rel4_bad;
   logic             unused_opc;

   assign fl         = flags_t'(word[IW-OPW-1 -: FLW]);
   assign disp_f     = word[DTOP -: DISPW];
   assign ext_f      = word[EXTW-1:0];
   assign leg_f      = word[LTOP -: LEGW];
   assign unused_opc = ^word[IW-1 -: OPW];
   assign legacy     = ~fl.n & ~fl.i;

   generate
      if (REL4_ILLEGAL) begin : g_rel4_flag
         assign rel4_bad = fl.e & (fl.b | fl.p);
      end else begin : g_rel4_ignore
         assign rel4_bad = 1'b0;
      end
   endgenerate

   always_comb begin
      if (legacy)          use_o = USE_SIMPLE;
      else if (fl.n & fl.i) use_o = USE_SIMPLE;
      else if (fl.i)        use_o = USE_IMM;
      else                  use_o = USE_IND;
   end

   assign ill_o = ~legacy & ((fl.x & (fl.n ^ fl.i)) | (fl.b & fl.p) | rel4_bad);
   assign len_o = (~legacy & fl.e) ? 3'd4 : 3'd3;
   assign idx_en_o = fl.x;

   always_comb begin
      src_o = SRC_ZERO;
      off_o = AW'(disp_f);
      if (legacy) begin
         off_o = AW'(leg_f);
      end else if (fl.e) begin
         off_o = AW'(ext_f);
      end else if (fl.p & ~fl.b) begin
         src_o = SRC_PC;
         off_o = AW'($signed(disp_f));
      end else if (fl.b & ~fl.p) begin
         src_o = SRC_BASE;
      end
   end

endmodule

// File: rtl/xta_adder.sv
module xta_adder
   import xta_pkg::*;
#(
   parameter int AW = 20
) (
   input  src_e          src,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] index,
   input  logic [AW-1:0] off,
   input  logic          idx_en,
   output logic [AW-1:0] sum
);
   logic [AW-1:0] lead;
   logic [AW-1:0] idx_term;

   always_comb begin
      case (src)
         SRC_PC:   lead = pc;
         SRC_BASE: lead = base;
         default:  lead = '0;
      endcase
   end

   assign idx_term = idx_en ? index : '0;
   assign sum      = lead + off + idx_term;

endmodule

// File: rtl/xta_ctrl.sv
module xta_ctrl
   import xta_pkg::*;
#(
   parameter int AW = 20,
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [AW-1:0] ta_in,
   input  use_e          use_in,
   input  logic [2:0]    len_in,
   input  logic          ill_in,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          out_valid,
   output logic [AW-1:0] out_ta,
   output use_e          out_use,
   output logic [2:0]    out_len,
   output logic          out_read,
   output logic          out_illegal
);
   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DONE} st_e;

   st_e           st;
   logic [AW-1:0] r_ta;
   use_e          r_use;
   logic [2:0]    r_len;
   logic          r_read;
   logic          r_ill;
   logic          accept;
   logic          unused_rdata;

   assign accept       = in_valid & in_ready;
   assign in_ready     = (st == ST_IDLE);
   assign mem_req      = (st == ST_FETCH);
   assign mem_addr     = r_ta;
   assign out_valid    = (st == ST_DONE);
   assign out_ta       = r_ta;
   assign out_use      = r_use;
   assign out_len      = r_len;
   assign out_read     = r_read;
   assign out_illegal  = r_ill;
   assign unused_rdata = ^mem_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         r_ta   <= '0;
         r_use  <= USE_SIMPLE;
         r_len  <= 3'd0;
         r_read <= 1'b0;
         r_ill  <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (accept) begin
               r_ta   <= ill_in ? '0 : ta_in;
               r_use  <= use_in;
               r_len  <= len_in;
               r_ill  <= ill_in;
               r_read <= ~ill_in & (use_in != USE_IMM);
               st     <= (~ill_in & (use_in == USE_IND)) ? ST_FETCH : ST_DONE;
            end
            ST_FETCH: if (mem_ack) begin
               r_ta <= mem_rdata[AW-1:0];
               st   <= ST_DONE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/xta_unit.sv
module xta_unit
   import xta_pkg::*;
#(
   parameter int IW           = 32,
   parameter int OPW          = 6,
   parameter int DISPW        = 12,
   parameter int AW           = 20,
   parameter int DW           = 24,
   parameter bit REL4_ILLEGAL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [IW-1:0] in_word,
   input  logic [AW-1:0] in_pc,
   input  logic [AW-1:0] in_base,
   input  logic [AW-1:0] in_index,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          out_valid,
   output logic [AW-1:0] out_ta,
   output logic [1:0]    out_use,
   output logic [2:0]    out_len,
   output logic          out_read,
   output logic          out_illegal
);
   localparam int EXTW = IW - OPW - 6;
   localparam int LEGW = DISPW + 3;

   generate
      if (IW % 8 != 0) begin : g_bad_iw
         $error("instruction width must be whole bytes");
      end
      if (EXTW < DISPW + 8) begin : g_bad_ext
         $error("extended field must cover the short field and the last byte");
      end
      if (AW < EXTW || AW <= LEGW) begin : g_bad_aw
         $error("address width too narrow for the address fields");
      end
      if (DW < AW) begin : g_bad_dw
         $error("pointer word narrower than an address");
      end
   endgenerate

   flags_t        fl;
   use_e          dec_use;
   use_e          o_use;
   logic          dec_ill;
   logic [2:0]    dec_len;
   src_e          dec_src;
   logic [AW-1:0] dec_off;
   logic          dec_idx;
   logic [AW-1:0] ta_sum;
   logic          unused_fl;

   assign unused_fl = ^fl;

   xta_decode #(
      .IW(IW), .OPW(OPW), .DISPW(DISPW), .AW(AW), .REL4_ILLEGAL(REL4_ILLEGAL)
   ) u_dec (
      .word(in_word), .fl(fl), .use_o(dec_use), .ill_o(dec_ill),
      .len_o(dec_len), .src_o(dec_src), .off_o(dec_off), .idx_en_o(dec_idx)
   );

   xta_adder #(.AW(AW)) u_add (
      .src(dec_src), .pc(in_pc), .base(in_base), .index(in_index),
      .off(dec_off), .idx_en(dec_idx), .sum(ta_sum)
   );

   xta_ctrl #(.AW(AW), .DW(DW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .ta_in(ta_sum), .use_in(dec_use), .len_in(dec_len), .ill_in(dec_ill),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ta(out_ta),
      .out_use(o_use), .out_len(out_len), .out_read(out_read),
      .out_illegal(out_illegal)
   );

   assign out_use = o_use;

endmodule

// File: rtl/xta_unit_chk.sv
module xta_unit_chk #(
   parameter int AW = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_ready,
   input logic          mem_req,
   input logic [AW-1:0] mem_addr,
   input logic          mem_ack,
   input logic          out_valid,
   input logic [AW-1:0] out_ta,
   input logic [1:0]    out_use,
   input logic          out_read,
   input logic          out_illegal
);
   assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

   assert_ind_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_use == 2'd2 && !out_illegal |-> $past(mem_req && mem_ack));

   assert_imm_noread_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_use == 2'd1 |-> !out_read);

   assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_illegal |-> !out_read && out_ta == '0);

   assert_ready_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> !in_ready);

   assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_req_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || out_valid) |-> !in_ready);

endmodule

bind xta_unit xta_unit_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
   .out_valid(out_valid), .out_ta(out_ta), .out_use(out_use),
   .out_read(out_read), .out_illegal(out_illegal)
);

// File: tb/xta_unit_test.sv
`timescale 1ns/1ps
module xta_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_word = '0;
   logic [19:0] in_pc = '0, in_base = '0, in_index = '0;
   logic        mem_req;
   logic [19:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [23:0] mem_rdata = '0;
   logic        out_valid;
   logic [19:0] out_ta;
   logic [1:0]  out_use;
   logic [2:0]  out_len;
   logic        out_read, out_illegal;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   xta_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .in_pc(in_pc), .in_base(in_base), .in_index(in_index),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ta(out_ta),
      .out_use(out_use), .out_len(out_len), .out_read(out_read),
      .out_illegal(out_illegal)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void model(input logic [31:0] w, input logic [19:0] pc, bs, ix,
                                 output logic [19:0] ta, output logic [1:0] use_c,
                                 output logic [2:0] len, output logic rd,
                                 output logic ill, output string tag);
      logic n, i, x, b, p, e;
      logic [11:0] d;
      logic [19:0] t;
      {n, i, x, b, p, e} = w[25:20];
      d = w[19:8];
      if (!n && !i) begin
         t = {5'b0, w[22:8]} + (x ? ix : 20'd0);
         use_c = 2'd0; len = 3'd3; ill = 1'b0; tag = "R9";
      end else begin
         use_c = (n && i) ? 2'd0 : (i ? 2'd1 : 2'd2);
         len = e ? 3'd4 : 3'd3;
         ill = (x && (n != i)) || (b && p) || (e && (b || p));
         if (e)             begin t = w[19:0];                tag = "R2"; end
         else if (p && !b)  begin t = pc + {{8{d[11]}}, d};   tag = "R3"; end
         else if (b && !p)  begin t = bs + {8'd0, d};         tag = "R4"; end
         else               begin t = {8'd0, d};              tag = "R2"; end
         if (x) begin t = t + ix; tag = "R5"; end
         if (ill) begin t = '0; tag = "R10"; end
      end
      ta = t;
      rd = !ill && use_c != 2'd1;
   endfunction

   function automatic string use_tag(input logic [1:0] u, input logic [31:0] w);
      if (!w[25] && !w[24]) return "R9";
      if (u == 2'd1) return "R6";
      if (u == 2'd2) return "R7";
      return "R8";
   endfunction

   task automatic run_one(input logic [31:0] w, input logic [19:0] pc, bs, ix,
                          input logic [23:0] ptr, input int delay);
      logic [19:0] ta;
      logic [1:0] u;
      logic [2:0] len;
      logic rd, ill;
      string tag;
      model(w, pc, bs, ix, ta, u, len, rd, ill, tag);
      @(negedge clk);
      chk("R11 ready when idle", {31'd0, in_ready}, 32'd1);
      in_word = w; in_pc = pc; in_base = bs; in_index = ix; in_valid = 1'b1;
      @(posedge clk); #1 in_valid = 1'b0;
      @(negedge clk);
      chk("R11 ready low when busy", {31'd0, in_ready}, 32'd0);
      if (!ill && u == 2'd2) begin
         chk("R7 request raised", {31'd0, mem_req}, 32'd1);
         chk({"R7 request address ", tag}, {12'd0, mem_addr}, {12'd0, ta});
         for (int k = 0; k < delay; k++) begin
            @(negedge clk);
            chk("R7 request held", {31'd0, mem_req}, 32'd1);
            chk("R7 address held", {12'd0, mem_addr}, {12'd0, ta});
            chk("R11 no early result", {31'd0, out_valid}, 32'd0);
         end
         mem_ack = 1'b1; mem_rdata = ptr;
         @(posedge clk); #1 mem_ack = 1'b0;
         @(negedge clk);
         ta = ptr[19:0];
         tag = "R7";
      end else begin
         chk({"R6 R10 no request ", tag}, {31'd0, mem_req}, 32'd0);
      end
      chk("R11 result pulse", {31'd0, out_valid}, 32'd1);
      chk({"target ", tag}, {12'd0, out_ta}, {12'd0, ta});
      chk({"use ", use_tag(u, w)}, {30'd0, out_use}, {30'd0, u});
      chk("R1 length", {29'd0, out_len}, {29'd0, len});
      chk({"read ", use_tag(u, w)}, {31'd0, out_read}, {31'd0, rd});
      chk("R10 illegal flag", {31'd0, out_illegal}, {31'd0, ill});
      @(negedge clk);
      chk("R11 pulse ends", {31'd0, out_valid}, 32'd0);
   endtask

   // word builder: opcode, n i x b p e, 20-bit field
   function automatic logic [31:0] mk(input logic [5:0] fl, input logic [19:0] f);
      return {6'b000011, fl, f};
   endfunction

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R11 reset ready", {31'd0, in_ready}, 32'd1);
      chk("R11 reset valid", {31'd0, out_valid}, 32'd0);
      chk("R11 reset request", {31'd0, mem_req}, 32'd0);
      rst_n = 1'b1;
      // R3 negative displacement wrapping below zero
      run_one(mk(6'b110010, 20'h80000), 20'h00000, 20'h0, 20'h0, 24'h0, 0);
      // R3 positive displacement
      run_one(mk(6'b110010, 20'h7FF00), 20'h00100, 20'h0, 20'h0, 24'h0, 0);
      // R4 base at the top of memory wraps
      run_one(mk(6'b110100, 20'hFFF00), 20'h0, 20'hFFFFF, 20'h0, 24'h0, 0);
      // R2 direct short and extended, R5 with index
      run_one(mk(6'b110000, 20'hABC00), 20'h12345, 20'h0, 20'h0, 24'h0, 0);
      run_one(mk(6'b111001, 20'hFFFF0), 20'h0, 20'h0, 20'h00020, 24'h0, 0);
      // R9 legacy with b p e used as address bits, plus index
      run_one({6'h0, 6'b001111, 20'hFFF00}, 20'h55555, 20'h11111, 20'h00001, 24'h0, 0);
      // R6 immediate
      run_one(mk(6'b010000, 20'h00300), 20'h0, 20'h0, 20'h0, 24'h0, 0);
      // R10 indexed immediate, indexed indirect, both relative, extended relative
      run_one(mk(6'b011000, 20'h00300), 20'h0, 20'h0, 20'h00007, 24'h0, 0);
      run_one(mk(6'b101000, 20'h00300), 20'h0, 20'h0, 20'h00007, 24'hABCDE, 0);
      run_one(mk(6'b110110, 20'h00300), 20'h0, 20'h0, 20'h0, 24'h0, 0);
      run_one(mk(6'b110011, 20'h00300), 20'h0, 20'h0, 20'h0, 24'h0, 0);
      // R7 indirect with stalled acknowledge
      run_one(mk(6'b100010, 20'h01000), 20'h02000, 20'h0, 20'h0, 24'hF12345, 3);
      // R8 simple
      run_one(mk(6'b110000, 20'h02A00), 20'h0, 20'h0, 20'h0, 24'h0, 0);
      for (int t = 0; t < 400; t++) begin
         run_one($urandom, 20'($urandom), 20'($urandom), 20'($urandom),
                 24'($urandom), int'($urandom_range(0, 3)));
      end
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(1_000_000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog R11 actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule